// File: doc/BRIEF.md
# USB Host Interrupt Status Controller

This block gathers the interrupt events of a full-speed USB host controller into one sticky status word. The events are scheduling overrun, done-head writeback, start of frame, resume from a device, a fatal system error, a frame-number rollover, a root-hub change and a request to change ownership. Each event sets its own status bit. Software reads the status word over a small register port and clears individual bits by writing ones to them.

A separate enable word selects which status bits may interrupt the host. Enable bits are set and cleared through two addresses. A master bit gates the combined request, which is registered before it leaves the block. The ownership-change bit does not feed the host request. It drives a management interrupt line directly, without a register stage.

The block also does the following:
- It keeps a 2-bit count of scheduling overruns.
- It drives a writeback permit that closes while the done-head bit is pending.
- It detects the events that are edges rather than pulses.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After reset, every status bit, every enable bit, the overrun count and both interrupt outputs are 0, and the writeback permit is 1. Status bits other than 0–6 and 30 always read 0, and writes do not change them. Enable bits other than 0–6, 30 and 31 always read 0, and writes do not change them.
- R2: The status word is at address 0. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R3: Status bit 5 is set in any cycle where bit 15 of the frame-number input differs from its value in the previous cycle. This holds for a change from 0 to 1 and for a change from 1 to 0.
- R4: Status bit 3 is set only when the device-resume input goes from 0 to 1. Holding the input high does not set the bit again after it is cleared. A rising edge is ignored while the software-resume input is 1.
- R5: A start-of-frame pulse sets status bit 2.
- R6: A done-head-written pulse sets status bit 1. The writeback-permit output is 0 while bit 1 is set and 1 while it is clear.
- R7: Each overrun pulse sets status bit 0 and adds 1 to a 2-bit counter on ovr_cnt_o. The counter wraps from 3 to 0.
- R8: An ownership request sets status bit 30. The management interrupt output is 1 while bit 30 is set and enable bit 30 is 1, with no register delay. When HAS_SMI is 0, bit 30 stays 0.
- R9: A root-hub change pulse sets status bit 6, and a system-error pulse sets status bit 4.
- R10: Writing to address 1 sets the enable bits written as 1. Writing to address 2 clears the enable bits written as 1. Reads from either address return the enable word.
- R11: One cycle after the inputs change, the host interrupt output equals enable bit 31 ANDed with the OR of (status & enable) over bits 0–6. Status bit 30 never affects the host interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| frame_num_i | input | 16 | Current frame number |
| sof_i | input | 1 | Start-of-frame pulse |
| resume_i | input | 1 | Device resume signalling level |
| sw_resume_i | input | 1 | Software-commanded resume state |
| wdh_done_i | input | 1 | Done-head written pulse |
| sched_ovr_i | input | 1 | Scheduling overrun pulse |
| sys_err_i | input | 1 | System error pulse |
| hub_chg_i | input | 1 | Root-hub status change pulse |
| own_req_i | input | 1 | Ownership change request pulse |
| wb_allow_o | output | 1 | Done-head writeback permitted |
| ovr_cnt_o | output | 2 | Overrun counter |
| host_irq_o | output | 1 | Host interrupt request, registered |
| smi_o | output | 1 | Management interrupt |

## Verification
The assertions rely on a few assumptions about the inputs:
- Event inputs are single-cycle pulses sampled on the clock.
- The frame number does not change while reset is held.
- Register writes use the four defined addresses only.

The stimulus keeps to these assumptions. It drives every input on the falling edge and lowers each pulse after one cycle. It holds the frame number at 0 through reset and changes bit 15 only on purpose. It writes only to addresses 0–3.

The stimulus also covers timing corner cases. It raises an event and a status clear in the same cycle. It holds the resume level high across a clear. It raises a resume edge while software resume is active.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;
  localparam int FN_W   = 16;
  localparam int CNT_W  = 2;

  localparam int B_OVR    = 0;
  localparam int B_WDONE  = 1;
  localparam int B_SOF    = 2;
  localparam int B_RSM    = 3;
  localparam int B_UERR   = 4;
  localparam int B_FOVF   = 5;
  localparam int B_HUB    = 6;
  localparam int B_OWN    = 30;
  localparam int B_MASTER = 31;

  localparam logic [REG_W-1:0] HOST_SRC_MASK = 32'h0000_007F;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT  = 2'd0,
    A_ENSET = 2'd1,
    A_ENCLR = 2'd2,
    A_CNT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_irq_edge.sv
module usb_irq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_msb_i,
  input  logic resume_i,
  input  logic sw_resume_i,
  output logic fovf_o,
  output logic rsm_o
);
  logic msb_q, resume_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      msb_q    <= frame_msb_i;
      resume_q <= resume_i;
    end
  end

  assign fovf_o = frame_msb_i ^ msb_q;
  // software-commanded resume is not a device event
  assign rsm_o  = resume_i & ~resume_q & ~sw_resume_i;

  p_resume_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsm_o |=> !rsm_o);
endmodule

// File: rtl/usb_irq_ovr_cnt.sv
module usb_irq_ovr_cnt #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovr_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ovr_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_ovr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
  p_ovr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_i |=> $stable(cnt_q));
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status #(
  parameter int             W         = 32,
  parameter logic [W-1:0]   IMPL_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~clr_i) | set_i) & IMPL_MASK;
  end

  assign stat_o = stat_q;

  p_set_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & IMPL_MASK)) |=>
      ((stat_q & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)));
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
  p_rsvd_stat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/usb_irq_enable.sv
module usb_irq_enable #(
  parameter int           W         = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= ((en_q | set_i) & ~clr_i) & IMPL_MASK;
  end

  assign en_o = en_q;

  p_en_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & IMPL_MASK & ~clr_i)) |=>
      ((en_q & $past(set_i & IMPL_MASK & ~clr_i)) == $past(set_i & IMPL_MASK & ~clr_i)));
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter bit HAS_SMI = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [FN_W-1:0]   frame_num_i,
  input  logic              sof_i,
  input  logic              resume_i,
  input  logic              sw_resume_i,
  input  logic              wdh_done_i,
  input  logic              sched_ovr_i,
  input  logic              sys_err_i,
  input  logic              hub_chg_i,
  input  logic              own_req_i,
  output logic              wb_allow_o,
  output logic [CNT_W-1:0]  ovr_cnt_o,
  output logic              host_irq_o,
  output logic              smi_o
);
  localparam logic [REG_W-1:0] OWN_BIT   = REG_W'(1) << B_OWN;
  localparam logic [REG_W-1:0] MST_BIT   = REG_W'(1) << B_MASTER;
  localparam logic [REG_W-1:0] STAT_MASK = HOST_SRC_MASK | (HAS_SMI ? OWN_BIT : '0);
  localparam logic [REG_W-1:0] EN_MASK   = HOST_SRC_MASK | OWN_BIT | MST_BIT;

  logic fovf, rsm;
  logic [REG_W-1:0] stat_set, stat_clr, en_set, en_clr, stat, en;
  logic host_irq_q;

  usb_irq_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_msb_i (frame_num_i[FN_W-1]),
    .resume_i    (resume_i),
    .sw_resume_i (sw_resume_i),
    .fovf_o      (fovf),
    .rsm_o       (rsm)
  );

  usb_irq_ovr_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovr_i  (sched_ovr_i),
    .cnt_o  (ovr_cnt_o)
  );

  always_comb begin
    stat_set          = '0;
    stat_set[B_OVR]   = sched_ovr_i;
    stat_set[B_WDONE] = wdh_done_i;
    stat_set[B_SOF]   = sof_i;
    stat_set[B_RSM]   = rsm;
    stat_set[B_UERR]  = sys_err_i;
    stat_set[B_FOVF]  = fovf;
    stat_set[B_HUB]   = hub_chg_i;
    stat_set[B_OWN]   = own_req_i;
  end

  assign stat_clr = (reg_we_i && reg_addr_i == A_STAT)  ? reg_wdata_i : '0;
  assign en_set   = (reg_we_i && reg_addr_i == A_ENSET) ? reg_wdata_i : '0;
  assign en_clr   = (reg_we_i && reg_addr_i == A_ENCLR) ? reg_wdata_i : '0;

  usb_irq_status #(.W(REG_W), .IMPL_MASK(STAT_MASK)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stat_set),
    .clr_i  (stat_clr),
    .stat_o (stat)
  );

  usb_irq_enable #(.W(REG_W), .IMPL_MASK(EN_MASK)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .en_o   (en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_irq_q <= 1'b0;
    else         host_irq_q <= en[B_MASTER] & (|(stat & en & HOST_SRC_MASK));
  end

  always_comb begin
    unique case (reg_addr_i)
      A_STAT:  reg_rdata_o = stat;
      A_ENSET: reg_rdata_o = en;
      A_ENCLR: reg_rdata_o = en;
      default: reg_rdata_o = REG_W'(ovr_cnt_o);
    endcase
  end

  assign host_irq_o = host_irq_q;
  assign smi_o      = stat[B_OWN] & en[B_OWN];
  assign wb_allow_o = ~stat[B_WDONE];

  p_rsvd_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_STAT) |-> (reg_rdata_o[29:7] == '0 && !reg_rdata_o[31]));
  p_fovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_num_i[FN_W-1] != $past(frame_num_i[FN_W-1])) |=> stat[B_FOVF]);
  p_wdh_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[B_WDONE] && !stat_clr[B_WDONE]) |=> (stat[B_WDONE] && !wb_allow_o));
  p_master_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[B_MASTER] |=> !host_irq_o);
  p_own_no_host_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & en & HOST_SRC_MASK) == '0) |=> !host_irq_o);

  if (HAS_SMI) begin : g_smi
    p_own_smi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_req_i && en[B_OWN] && !en_clr[B_OWN]) |=> smi_o);
  end else begin : g_no_smi
    p_own_absent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stat[B_OWN] && !smi_o);
  end
endmodule

// File: tb/tb_usb_irq_ctrl.sv
module tb_usb_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] frame_num_i = '0;
  logic sof_i = 0, resume_i = 0, sw_resume_i = 0, wdh_done_i = 0;
  logic sched_ovr_i = 0, sys_err_i = 0, hub_chg_i = 0, own_req_i = 0;
  logic wb_allow_o, host_irq_o, smi_o;
  logic [1:0] ovr_cnt_o;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  bit done = 0;

  usb_irq_ctrl dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0; reg_wdata_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic drive_ev(int b, logic v);
    case (b)
      0: sched_ovr_i = v;
      1: wdh_done_i = v;
      2: sof_i = v;
      3: resume_i = v;
      4: sys_err_i = v;
      5: if (v) frame_num_i[15] = ~frame_num_i[15];
      6: hub_chg_i = v;
      30: own_req_i = v;
      default: ;
    endcase
  endtask

  task automatic pulse(int b);
    @(negedge clk_i);
    drive_ev(b, 1'b1);
    if (b == 0) exp_cnt = (exp_cnt + 1) % 4;
    @(negedge clk_i);
    drive_ev(b, 1'b0);
  endtask

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bits[8] = '{0, 1, 2, 3, 4, 5, 6, 30};
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 enable", d, 0);
    chk("R1 irq/smi/wb/cnt", {host_irq_o, smi_o, wb_allow_o, ovr_cnt_o}, 5'b00100);

    // R3 R4 R5 R6 R7 R8 R9 each event alone, then W1C (R2)
    foreach (bits[i]) begin
      pulse(bits[i]);
      rd(0, d); chk($sformatf("R9/R3-R8 event bit %0d", bits[i]), d, 32'h1 << bits[i]);
      if (bits[i] == 1) chk("R6 wb_allow low", wb_allow_o, 0);
      wr(0, 32'h1 << bits[i]);
      rd(0, d); chk("R2 w1c clears", d, 0);
      if (bits[i] == 1) chk("R6 wb_allow high", wb_allow_o, 1);
    end
    resume_i = 0;

    // R1 reserved bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R1 status reserved", d, 0);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R1 enable impl mask", d, 32'hC000_007F);
    rd(2, d); chk("R10 enable via addr2", d, 32'hC000_007F);
    wr(2, 32'h0000_00F0);
    rd(1, d); chk("R10 w1c enable", d, 32'hC000_000F);
    wr(2, 32'hFFFF_FFFF);
    rd(1, d); chk("R10 cleared", d, 0);

    // R2 set wins over simultaneous clear
    @(negedge clk_i);
    sof_i = 1; reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 32'h4;
    @(negedge clk_i);
    sof_i = 0; reg_we_i = 0; reg_wdata_i = 0;
    rd(0, d); chk("R2 set wins", d, 32'h4);
    wr(0, 32'h4);

    // R3 both directions, low bits no effect
    @(negedge clk_i); frame_num_i = 16'h7FFF;
    @(negedge clk_i); frame_num_i = 16'h8000;
    @(negedge clk_i); rd(0, d); chk("R3 rise", d, 32'h20);
    wr(0, 32'h20);
    @(negedge clk_i); frame_num_i = 16'h8001;
    @(negedge clk_i); rd(0, d); chk("R3 low bits ignored", d, 0);
    frame_num_i = 16'h0000;
    @(negedge clk_i); rd(0, d); chk("R3 fall", d, 32'h20);
    wr(0, 32'h20);

    // R4 held level sets once; software resume masks
    @(negedge clk_i); resume_i = 1;
    @(negedge clk_i); rd(0, d); chk("R4 edge", d, 32'h8);
    wr(0, 32'h8);
    repeat (3) @(negedge clk_i);
    rd(0, d); chk("R4 held no reset", d, 0);
    resume_i = 0; sw_resume_i = 1;
    @(negedge clk_i); resume_i = 1;
    @(negedge clk_i); rd(0, d); chk("R4 sw resume ignored", d, 0);
    resume_i = 0; sw_resume_i = 0;

    // R7 counter wraps
    for (int k = 0; k < 5; k++) begin
      pulse(0);
      chk("R7 count", ovr_cnt_o, exp_cnt);
    end
    rd(3, d); chk("R7 count readback", d, exp_cnt);
    wr(0, 32'h1);

    // R11 sweep all masks with all host sources pending
    for (int b = 0; b < 7; b++) pulse(b);
    resume_i = 0;
    for (int m = 0; m < 128; m++) begin
      for (int ms = 0; ms < 2; ms++) begin
        wr(2, 32'hFFFF_FFFF);
        wr(1, m | (ms << 31));
        @(negedge clk_i);
        chk($sformatf("R11 mask %0h master %0d", m, ms), host_irq_o, (ms == 1 && m != 0));
      end
    end
    wr(0, 32'hFFFF_FFFF);
    // R11 single source behaviour and latency
    wr(2, 32'hFFFF_FFFF);
    wr(1, 32'h8000_0004);
    pulse(2);
    chk("R11 not yet", host_irq_o, 0);
    @(negedge clk_i);
    chk("R11 after one cycle", host_irq_o, 1);
    wr(0, 32'h4);
    @(negedge clk_i);
    chk("R11 drops", host_irq_o, 0);

    // R8 ownership: smi immediate, host irq unaffected
    wr(1, 32'hC000_0000);
    pulse(30);
    chk("R8 smi", smi_o, 1);
    @(negedge clk_i);
    chk("R11 own not host", host_irq_o, 0);
    wr(2, 32'h4000_0000);
    chk("R8 smi masked", smi_o, 0);
    rd(0, d); chk("R8 status kept", d, 32'h4000_0000);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule